// File: doc/BRIEF.md
# DRAM Rank Command Timing Guard

This block sits between a memory controller's command scheduler and a single DRAM rank. Each DRAM clock the scheduler presents at most one command request: a command code, a bank number and a valid flag. The guard answers in the same cycle with a grant when issuing the command breaks none of the rank's spacing rules, or a stall when it would. The scheduler holds a stalled request stable until it is granted, so the block accepts at most one command per clock.

The guard enforces activate-to-activate spacing, a sliding window that admits at most four activates, write-to-read turnaround at rank level, read-to-precharge and write recovery for each bank, and a refresh quiet period that blocks every command. The spacing values come from configuration inputs. Each one is raised to its legal floor, and the result is copied into internal registers only during an idle cycle. An idle cycle is one with no request and with every spacing window already expired. A timing change can therefore never shorten or stretch a window that is already running.

Top module: `rank_cmd_guard`

## Requirements
- R1: After reset, every timer and the activate history are clear, so the first legal command is granted at once. With no valid request, grant_o and stall_o are both low.
- R2: An activate is granted only when at least T_rrd clocks have passed since the last granted activate, in any bank. T_rrd is the configured value raised to at least 4.
- R3: A fifth activate is granted only when the fourth most recent granted activate lies at least T_faw clocks in the past. T_faw is the configured value raised to at least 4×T_rrd.
- R4: A read to any bank is granted only when at least T_wtr clocks have passed since the last granted write to any bank. T_wtr is the configured value raised to at least 4.
- R5: A precharge to bank b is granted only when at least T_rtp clocks have passed since the last granted read to bank b. T_rtp is the configured value raised to at least 4. Reads to other banks do not delay it.
- R6: A precharge to bank b is granted only when at least T_wr clocks have passed since the last granted write to bank b. T_wr is the configured value raised to at least 1.
- R7: After a granted refresh, no command is granted for T_rfc clocks. T_rfc is the configured value raised to at least 1. Writes and refreshes have no other restriction.
- R8: The command codes are 1 activate, 2 read, 3 write, 4 precharge and 5 refresh. Codes 0, 6 and 7 are neither granted nor stalled, and they leave all timing state unchanged.
- R9: stall_o is high exactly when a valid request with a legal code is not granted. grant_o and stall_o are never high together.
- R10: The configuration inputs take effect only after an idle cycle: one with no valid request and every window expired. From reset the effective values are 4, 16, 4, 4, DEF_TWR (9) and DEF_TRFC (44), for T_rrd, T_faw, T_wtr, T_rtp, T_wr and T_rfc respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | DRAM clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Command request present |
| req_cmd_i | input | 3 | Command code |
| req_bank_i | input | $clog2(NUM_BANKS) | Target bank |
| cfg_trrd_i | input | TW | Activate-to-activate spacing |
| cfg_tfaw_i | input | TW+2 | Four-activate window length |
| cfg_twtr_i | input | TW | Write-to-read spacing |
| cfg_trtp_i | input | TW | Read-to-precharge spacing |
| cfg_twr_i | input | TW | Write recovery |
| cfg_trfc_i | input | RFC_W | Refresh cycle time |
| grant_o | output | 1 | Request may issue this clock |
| stall_o | output | 1 | Request must wait |

## Verification
The activate spacing check and the four-activate window can both block the same activate. The window can also open in the very cycle the spacing counter reaches zero. Activate streams with a tight spacing and a window above four times that spacing make the two limits alternate, and a bench reference model judges every cycle against the time stamps of the granted commands. A second collision arises when a configuration change arrives while windows are still running. The bench changes the inputs in the middle of held activate streams and during random traffic, and checks that the old spacing stays in force until the model sees an idle cycle.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } cmd_e;

  localparam int unsigned MIN_TRRD = 4;
  localparam int unsigned MIN_TWTR = 4;
  localparam int unsigned MIN_TRTP = 4;
  localparam int unsigned FAW_ACTS = 4;
endpackage

// File: rtl/rcg_gap_cnt.sv
module rcg_gap_cnt #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i - W'(1);
    else if (cnt_q != '0)      cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);

  // R2: running window shrinks by exactly one per clock
  a_r2_gap_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - W'(1));
endmodule

// File: rtl/rcg_cfg_sample.sv
module rcg_cfg_sample
  import rcg_pkg::*;
#(
  parameter int unsigned TW       = 6,
  parameter int unsigned FAW_W    = TW + 2,
  parameter int unsigned RFC_W    = 8,
  parameter int unsigned DEF_TWR  = 9,
  parameter int unsigned DEF_TRFC = 44
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic [TW-1:0]    cfg_trrd_i,
  input  logic [FAW_W-1:0] cfg_tfaw_i,
  input  logic [TW-1:0]    cfg_twtr_i,
  input  logic [TW-1:0]    cfg_trtp_i,
  input  logic [TW-1:0]    cfg_twr_i,
  input  logic [RFC_W-1:0] cfg_trfc_i,
  output logic [TW-1:0]    eff_trrd_o,
  output logic [FAW_W-1:0] eff_tfaw_o,
  output logic [TW-1:0]    eff_twtr_o,
  output logic [TW-1:0]    eff_trtp_o,
  output logic [TW-1:0]    eff_twr_o,
  output logic [RFC_W-1:0] eff_trfc_o
);
  logic [TW-1:0]    trrd_c, twtr_c, trtp_c, twr_c;
  logic [FAW_W-1:0] faw_floor, tfaw_c;
  logic [RFC_W-1:0] trfc_c;

  always_comb begin
    trrd_c    = (cfg_trrd_i < TW'(MIN_TRRD)) ? TW'(MIN_TRRD) : cfg_trrd_i;
    faw_floor = {trrd_c, 2'b00};
    tfaw_c    = (cfg_tfaw_i < faw_floor) ? faw_floor : cfg_tfaw_i;
    twtr_c    = (cfg_twtr_i < TW'(MIN_TWTR)) ? TW'(MIN_TWTR) : cfg_twtr_i;
    trtp_c    = (cfg_trtp_i < TW'(MIN_TRTP)) ? TW'(MIN_TRTP) : cfg_trtp_i;
    twr_c     = (cfg_twr_i == '0) ? TW'(1) : cfg_twr_i;
    trfc_c    = (cfg_trfc_i == '0) ? RFC_W'(1) : cfg_trfc_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eff_trrd_o <= TW'(MIN_TRRD);
      eff_tfaw_o <= FAW_W'(FAW_ACTS * MIN_TRRD);
      eff_twtr_o <= TW'(MIN_TWTR);
      eff_trtp_o <= TW'(MIN_TRTP);
      eff_twr_o  <= TW'(DEF_TWR);
      eff_trfc_o <= RFC_W'(DEF_TRFC);
    end else if (sample_i) begin
      eff_trrd_o <= trrd_c;
      eff_tfaw_o <= tfaw_c;
      eff_twtr_o <= twtr_c;
      eff_trtp_o <= trtp_c;
      eff_twr_o  <= twr_c;
      eff_trfc_o <= trfc_c;
    end
  end

  // R10: effective timing moves only after an idle sample
  a_r10_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> ($stable(eff_trrd_o) && $stable(eff_tfaw_o) && $stable(eff_twtr_o)
                   && $stable(eff_trtp_o) && $stable(eff_twr_o) && $stable(eff_trfc_o)));
endmodule

// File: rtl/rcg_faw_window.sv
module rcg_faw_window
  import rcg_pkg::*;
#(
  parameter int unsigned FAW_W = 8,
  parameter int unsigned CW    = FAW_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic [FAW_W-1:0] tfaw_i,
  output logic             block_o,
  output logic             live_any_o
);
  localparam int unsigned PW = $clog2(FAW_ACTS);

  logic [CW-1:0] cyc_q;
  logic [CW-1:0] stamp_q [FAW_ACTS];
  logic [FAW_ACTS-1:0] vld_q, live;
  logic [PW-1:0] wptr_q;

  for (genvar i = 0; i < FAW_ACTS; i++) begin : g_age
    logic [CW-1:0] age;
    assign age     = cyc_q - stamp_q[i];
    assign live[i] = vld_q[i] && (age < CW'(tfaw_i));
  end

  assign block_o    = &live;
  assign live_any_o = |live;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      wptr_q <= '0;
      vld_q  <= '0;
      for (int i = 0; i < FAW_ACTS; i++) stamp_q[i] <= '0;
    end else begin
      cyc_q <= cyc_q + CW'(1);
      for (int i = 0; i < FAW_ACTS; i++) begin
        if (act_i && wptr_q == PW'(i)) begin
          stamp_q[i] <= cyc_q;
          vld_q[i]   <= 1'b1;
        end else if (vld_q[i] && !live[i]) begin
          vld_q[i] <= 1'b0;  // expire before the counter can wrap
        end
      end
      if (act_i) wptr_q <= wptr_q + PW'(1);
    end
  end

  // R3: no activate accepted while four are inside the window
  a_r3_no_fifth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> !block_o);
endmodule

// File: rtl/rcg_bank_timers.sv
module rcg_bank_timers #(
  parameter int unsigned NB = 8,
  parameter int unsigned BW = (NB > 1) ? $clog2(NB) : 1,
  parameter int unsigned TW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [BW-1:0] bank_i,
  input  logic [TW-1:0] trtp_i,
  input  logic [TW-1:0] twr_i,
  output logic [NB-1:0] pre_ok_o,
  output logic          busy_o
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic sel, rtp_zero, wr_zero;
    assign sel = (bank_i == BW'(b));

    rcg_gap_cnt #(.W(TW)) u_rtp (
      .clk_i, .rst_ni,
      .load_i(rd_i && sel), .load_val_i(trtp_i), .zero_o(rtp_zero)
    );
    rcg_gap_cnt #(.W(TW)) u_wrr (
      .clk_i, .rst_ni,
      .load_i(wr_i && sel), .load_val_i(twr_i), .zero_o(wr_zero)
    );

    assign pre_ok_o[b] = rtp_zero && wr_zero;
  end

  assign busy_o = ~&pre_ok_o;

  // R5: a read closes the precharge path of its own bank for the next clock
  a_r5_rd_blocks_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && trtp_i > TW'(1)) |=> !pre_ok_o[$past(bank_i)]);
endmodule

// File: rtl/rank_cmd_guard.sv
module rank_cmd_guard
  import rcg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned TW        = 6,
  parameter int unsigned RFC_W     = 8,
  parameter int unsigned DEF_TWR   = 9,
  parameter int unsigned DEF_TRFC  = 44,
  localparam int unsigned BW       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned FAW_W    = TW + 2,
  localparam int unsigned CW       = FAW_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [2:0]       req_cmd_i,
  input  logic [BW-1:0]    req_bank_i,
  input  logic [TW-1:0]    cfg_trrd_i,
  input  logic [FAW_W-1:0] cfg_tfaw_i,
  input  logic [TW-1:0]    cfg_twtr_i,
  input  logic [TW-1:0]    cfg_trtp_i,
  input  logic [TW-1:0]    cfg_twr_i,
  input  logic [RFC_W-1:0] cfg_trfc_i,
  output logic             grant_o,
  output logic             stall_o
);
  cmd_e cmd;
  logic legal, ok, idle;
  logic gnt_act, gnt_rd, gnt_wr, gnt_ref;
  logic rrd_zero, wtr_zero, rfc_zero, faw_block, faw_live, banks_busy;
  logic [NUM_BANKS-1:0] pre_ok;

  logic [TW-1:0]    eff_trrd, eff_twtr, eff_trtp, eff_twr;
  logic [FAW_W-1:0] eff_tfaw;
  logic [RFC_W-1:0] eff_trfc;

  assign cmd = cmd_e'(req_cmd_i);

  always_comb begin
    legal = 1'b1;
    ok    = 1'b0;
    unique case (cmd)
      CMD_ACT: ok = rrd_zero && !faw_block;
      CMD_RD:  ok = wtr_zero;
      CMD_WR:  ok = 1'b1;
      CMD_PRE: ok = pre_ok[req_bank_i];
      CMD_REF: ok = 1'b1;
      default: legal = 1'b0;
    endcase
  end

  assign grant_o = req_valid_i && legal && rfc_zero && ok;
  assign stall_o = req_valid_i && legal && !grant_o;

  assign gnt_act = grant_o && cmd == CMD_ACT;
  assign gnt_rd  = grant_o && cmd == CMD_RD;
  assign gnt_wr  = grant_o && cmd == CMD_WR;
  assign gnt_ref = grant_o && cmd == CMD_REF;

  assign idle = !req_valid_i && rfc_zero && rrd_zero && wtr_zero
                && !banks_busy && !faw_live;

  rcg_cfg_sample #(
    .TW(TW), .FAW_W(FAW_W), .RFC_W(RFC_W), .DEF_TWR(DEF_TWR), .DEF_TRFC(DEF_TRFC)
  ) u_cfg (
    .clk_i, .rst_ni, .sample_i(idle),
    .cfg_trrd_i, .cfg_tfaw_i, .cfg_twtr_i, .cfg_trtp_i, .cfg_twr_i, .cfg_trfc_i,
    .eff_trrd_o(eff_trrd), .eff_tfaw_o(eff_tfaw), .eff_twtr_o(eff_twtr),
    .eff_trtp_o(eff_trtp), .eff_twr_o(eff_twr), .eff_trfc_o(eff_trfc)
  );

  rcg_gap_cnt #(.W(TW)) u_rrd (
    .clk_i, .rst_ni, .load_i(gnt_act), .load_val_i(eff_trrd), .zero_o(rrd_zero)
  );
  rcg_gap_cnt #(.W(TW)) u_wtr (
    .clk_i, .rst_ni, .load_i(gnt_wr), .load_val_i(eff_twtr), .zero_o(wtr_zero)
  );
  rcg_gap_cnt #(.W(RFC_W)) u_rfc (
    .clk_i, .rst_ni, .load_i(gnt_ref), .load_val_i(eff_trfc), .zero_o(rfc_zero)
  );

  rcg_faw_window #(.FAW_W(FAW_W), .CW(CW)) u_faw (
    .clk_i, .rst_ni, .act_i(gnt_act), .tfaw_i(eff_tfaw),
    .block_o(faw_block), .live_any_o(faw_live)
  );

  rcg_bank_timers #(.NB(NUM_BANKS), .BW(BW), .TW(TW)) u_banks (
    .clk_i, .rst_ni, .rd_i(gnt_rd), .wr_i(gnt_wr), .bank_i(req_bank_i),
    .trtp_i(eff_trtp), .twr_i(eff_twr), .pre_ok_o(pre_ok), .busy_o(banks_busy)
  );

  // R9: one answer per request
  a_r9_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && stall_o));

  // R7: refresh quiets the rank on the following clock
  a_r7_ref_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_ref && eff_trfc > RFC_W'(1)) |=> !grant_o);

  // R2: back-to-back activates never both granted
  a_r2_act_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_act |=> !gnt_act);

  // R4: write immediately followed by read is refused
  a_r4_wtr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_wr |=> !gnt_rd);
endmodule

// File: tb/rank_cmd_guard_bench.sv
module rank_cmd_guard_bench;
  localparam int NB = 8;
  localparam int BW = 3;
  localparam int TW = 6;
  localparam int FW = TW + 2;
  localparam int RW = 8;
  localparam int NEVER = -100000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_cmd = 3'd0;
  logic [BW-1:0] req_bank = '0;
  logic [TW-1:0] c_trrd = '0, c_twtr = '0, c_trtp = '0, c_twr = '0;
  logic [FW-1:0] c_tfaw = '0;
  logic [RW-1:0] c_trfc = '0;
  logic grant_o, stall_o;

  int checks = 0;
  int failures = 0;

  // reference model state
  int t = 0;
  int last_act = NEVER;
  int act_h [4] = '{NEVER, NEVER, NEVER, NEVER};
  int act_w = 0;
  int wr_t = NEVER;
  int ref_t = NEVER;
  int rd_b [NB];
  int wr_b [NB];
  int e_trrd = 4, e_tfaw = 16, e_twtr = 4, e_trtp = 4, e_twr = 9, e_trfc = 44;
  logic last_exp = 1'b0;
  logic last_stall = 1'b0;

  always #10 clk = ~clk;

  rank_cmd_guard u_rank_cmd_guard (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_cmd_i(req_cmd), .req_bank_i(req_bank),
    .cfg_trrd_i(c_trrd), .cfg_tfaw_i(c_tfaw), .cfg_twtr_i(c_twtr),
    .cfg_trtp_i(c_trtp), .cfg_twr_i(c_twr), .cfg_trfc_i(c_trfc),
    .grant_o(grant_o), .stall_o(stall_o)
  );

  function automatic int at_least(int v, int m);
    return (v < m) ? m : v;
  endfunction

  function automatic logic exp_grant(logic v, logic [2:0] c, int b);
    logic ok;
    if (!v) return 1'b0;
    if (t - ref_t < e_trfc) return 1'b0;
    case (c)
      3'd1: ok = (t - last_act >= e_trrd) && (t - act_h[act_w] >= e_tfaw);
      3'd2: ok = (t - wr_t >= e_twtr);
      3'd3: ok = 1'b1;
      3'd4: ok = (t - rd_b[b] >= e_trtp) && (t - wr_b[b] >= e_twr);
      3'd5: ok = 1'b1;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic model_idle(logic v);
    logic r;
    r = !v && (t - ref_t >= e_trfc) && (t - last_act >= e_trrd) && (t - wr_t >= e_twtr);
    for (int i = 0; i < 4; i++) if (t - act_h[i] < e_tfaw) r = 1'b0;
    for (int b = 0; b < NB; b++)
      if ((t - rd_b[b] < e_trtp) || (t - wr_b[b] < e_twr)) r = 1'b0;
    return r;
  endfunction

  function automatic string auto_tag(logic [2:0] c);
    case (c)
      3'd1: return "R2 R3";
      3'd2: return "R4";
      3'd4: return "R5 R6";
      3'd3, 3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic run_cycle(logic v, logic [2:0] c, int b, string tag);
    logic eg, es, legal, idl;
    string tg;
    req_valid = v; req_cmd = c; req_bank = BW'(b);
    #5;
    legal = (c >= 3'd1 && c <= 3'd5);
    eg = exp_grant(v, c, b);
    es = v && legal && !eg;
    tg = (tag == "") ? auto_tag(c) : tag;
    checks++;
    if (grant_o !== eg || stall_o !== es) begin
      failures++;
      $display("FAIL %s R9 t=%0d cmd=%0d bank=%0d got grant=%b stall=%b exp grant=%b stall=%b",
               tg, t, c, b, grant_o, stall_o, eg, es);
    end
    idl = model_idle(v);
    @(posedge clk);
    if (eg) begin
      case (c)
        3'd1: begin last_act = t; act_h[act_w] = t; act_w = (act_w + 1) % 4; end
        3'd2: rd_b[b] = t;
        3'd3: begin wr_t = t; wr_b[b] = t; end
        3'd5: ref_t = t;
        default: ;
      endcase
    end
    if (idl) begin
      e_trrd = at_least(int'(c_trrd), 4);
      e_tfaw = at_least(int'(c_tfaw), 4 * e_trrd);
      e_twtr = at_least(int'(c_twtr), 4);
      e_trtp = at_least(int'(c_trtp), 4);
      e_twr  = at_least(int'(c_twr), 1);
      e_trfc = at_least(int'(c_trfc), 1);
    end
    t++;
    last_exp = eg;
    last_stall = es;
    @(negedge clk);
  endtask

  task automatic run_n(logic v, logic [2:0] c, int b, int n, string tag);
    for (int i = 0; i < n; i++) run_cycle(v, c, b, tag);
  endtask

  task automatic act_stream(int n, string tag);
    int bk = 0;
    for (int i = 0; i < n; i++) begin
      run_cycle(1'b1, 3'd1, bk, tag);
      if (last_exp) bk = (bk + 1) % NB;
    end
  endtask

  task automatic set_cfg(int rrd, int faw, int wtr, int rtp, int wr, int rfc);
    c_trrd = TW'(rrd); c_tfaw = FW'(faw); c_twtr = TW'(wtr);
    c_trtp = TW'(rtp); c_twr = TW'(wr); c_trfc = RW'(rfc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic v;
    logic [2:0] c;
    int b;
    void'($urandom(32'd2718));
    for (int i = 0; i < NB; i++) begin rd_b[i] = NEVER; wr_b[i] = NEVER; end
    // R10: large config during reset, request held so no idle sample
    set_cfg(20, 0, 10, 10, 20, 100);
    req_valid = 1'b1; req_cmd = 3'd1; req_bank = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: first activate granted; R10: default spacing of 4 and window of 16
    run_cycle(1'b1, 3'd1, 0, "R1");
    act_stream(24, "R10");

    // R1 and R9: no request, no answer; idle gap samples new config
    set_cfg(1, 5, 2, 7, 12, 30);
    run_n(1'b0, 3'd1, 0, 300, "R1");

    // R2 and R3 with clamped tRRD 4 and tFAW 16
    act_stream(40, "R2 R3");
    set_cfg(5, 30, 2, 7, 12, 30);
    run_n(1'b0, 3'd0, 0, 300, "R9");
    // R3: window 30 exceeds 4x5
    act_stream(50, "R3");
    // R10: change mid-stream, spacing must stay 5
    set_cfg(9, 40, 2, 7, 12, 30);
    act_stream(30, "R10");
    run_n(1'b0, 3'd0, 0, 300, "R10");
    set_cfg(5, 30, 2, 7, 12, 30);
    run_n(1'b0, 3'd0, 0, 300, "R10");

    // R4: write then read to another bank, clamped to 4
    run_cycle(1'b1, 3'd3, 2, "R4");
    run_n(1'b1, 3'd2, 3, 6, "R4");
    // R5: read then precharge same bank (7), other bank free
    run_cycle(1'b1, 3'd2, 1, "R5");
    run_cycle(1'b1, 3'd4, 2, "R5");
    run_n(1'b1, 3'd4, 1, 8, "R5");
    // R6: write then precharge same bank (12)
    run_cycle(1'b1, 3'd3, 4, "R6");
    run_n(1'b1, 3'd4, 4, 14, "R6");
    // R7: refresh blocks everything for 30
    run_cycle(1'b1, 3'd5, 0, "R7");
    run_n(1'b1, 3'd3, 5, 10, "R7");
    run_n(1'b1, 3'd1, 6, 22, "R7");
    // R8: illegal codes ignored, then activate free at once
    run_n(1'b0, 3'd0, 0, 300, "R8");
    run_cycle(1'b1, 3'd0, 0, "R8");
    run_cycle(1'b1, 3'd6, 1, "R8");
    run_cycle(1'b1, 3'd7, 2, "R8");
    run_cycle(1'b1, 3'd1, 3, "R8");
    run_cycle(1'b1, 3'd7, 3, "R8");
    run_cycle(1'b1, 3'd2, 3, "R8");

    // random traffic, requests held while stalled
    v = 1'b0; c = 3'd0; b = 0;
    for (int i = 0; i < 4000; i++) begin
      if (!last_stall) begin
        v = ($urandom % 10) < 8;
        c = 3'(($urandom % 8));
        if ($urandom % 3 == 0) c = 3'd1;
        b = int'($urandom % NB);
      end
      if ($urandom % 500 == 0)
        set_cfg(int'($urandom % 12), int'($urandom % 64), int'($urandom % 10),
                int'($urandom % 10), int'($urandom % 16), int'($urandom % 60));
      if (!last_stall && $urandom % 700 == 0) run_n(1'b0, 3'd0, 0, 280, "R10");
      run_cycle(v, c, b, "");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule